// File: doc/BRIEF.md
# Machine-Cycle Sequencer and Bus Strobe Shaper

This block paces the machine cycle of a small 8-bit controller core. Every cycle is made of five machine states, and every state is split into three crystal sub-phases. The block runs on the raw crystal clock. A clock-enable input selects which crystal edges move the sequencer forward. The block reports the current state and sub-phase so that the decoder can schedule its own work. It also drives the external bus strobes, all active low: address latch enable, expander program strobe, read and write.

The decoder presents its requests for a cycle: bus read, bus write, expander access and pending interrupt. The block captures them at one fixed point, on the enabled edge that leaves XTAL3 of state 1. For the rest of the cycle it shapes the strobes from that snapshot. Read and write are low for the whole of state 2 and rise at the end of its XTAL3, so their rising edge can act as the transfer strobe. The expander strobe is a single XTAL3 pulse inside state 2. A sample pulse during XTAL3 of state 2 in read cycles tells the decoder to latch the data bus as the read pulse ends. A pending interrupt cancels the bus read.

Top module: `mcyc_timing`

## Requirements
- R1: A synchronous active-high reset brings the outputs to state 1, sub-phase 1 (mstate=1, xphase=1) on the next clock. All four strobes go high and bus_sample goes low.
- R2: On a clock edge where clk_en is low, the state, the sub-phase and every strobe output keep their values.
- R3: On each enabled edge the sub-phase steps 1, 2, 3. After sub-phase 3 it returns to 1 and the state advances by one. After state 5, sub-phase 3, the sequencer wraps to state 1, sub-phase 1.
- R4: ale_n is low in state 4 sub-phase 3, and in state 5 sub-phases 1 and 2. It is high at every other position, in every cycle.
- R5: rd_n is low for all three sub-phases of state 2 when a read was captured for that cycle, and high everywhere else. It rises as the sequencer leaves state 2, sub-phase 3.
- R6: wr_n is low for all three sub-phases of state 2 when req_wr was high at the capture edge, and high everywhere else.
- R7: prog_n is low only in state 2, sub-phase 3, and only when req_exp was high at the capture edge.
- R8: bus_sample is high only in state 2, sub-phase 3 of a cycle with a captured read. rd_n is then low.
- R9: irq_pend is registered on every crystal edge, whatever the state of clk_en. If that registered value is high at the capture edge, the read is dropped: rd_n and bus_sample stay inactive for the cycle. The write and expander requests are captured unchanged.
- R10: Requests are captured only on the enabled edge leaving state 1, sub-phase 3. Values the request inputs hold at any other edge have no effect on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base crystal clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Qualifies the crystal edges that advance the sequencer |
| req_rd | input | 1 | Decoder asks for a bus read in this cycle |
| req_wr | input | 1 | Decoder asks for a bus write in this cycle |
| req_exp | input | 1 | Decoder asks for an expander access in this cycle |
| irq_pend | input | 1 | An interrupt is pending |
| ale_n | output | 1 | Address latch enable, active low |
| prog_n | output | 1 | Expander program strobe, active low |
| rd_n | output | 1 | Bus read strobe, active low |
| wr_n | output | 1 | Bus write strobe, active low |
| bus_sample | output | 1 | Tells the decoder to latch the data bus |
| mstate | output | 3 | Current machine state, 1 to 5 |
| xphase | output | 2 | Current crystal sub-phase, 1 to 3 |

## Verification
Two things can land on the same capture edge: a pending interrupt and a bus read request. Often a write or expander request arrives there too. The bench holds irq_pend, req_rd and req_wr high together across several cycles. It expects rd_n and bus_sample to stay quiet while wr_n still falls in state 2, and then expects the read to come back once the interrupt clears. Random clock-enable gaps are mixed into the run so that the capture edge sometimes falls just after an interrupt edge that arrived while the sequencer was stalled. A behavioural model in the bench judges every output on every clock.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int unsigned N_STATES = 5;
    localparam int unsigned N_PHASES = 3;
    localparam int unsigned ST_W     = $clog2(N_STATES + 1);
    localparam int unsigned PH_W     = $clog2(N_PHASES + 1);

    typedef logic [ST_W-1:0] state_t;
    typedef logic [PH_W-1:0] phase_t;

    // state that closes the capture window, state carrying bus transfers,
    // state whose last sub-phase opens the address latch window
    localparam state_t CAP_ST = state_t'(1);
    localparam state_t XFR_ST = state_t'(2);
    localparam state_t ALE_ST = state_t'(4);
    localparam state_t LAST_ST = state_t'(N_STATES);
    localparam phase_t LAST_PH = phase_t'(N_PHASES);

    typedef struct packed {
        state_t st;
        phase_t ph;
    } pos_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic expd;
    } req_t;

    typedef struct packed {
        logic ale_n;
        logic prog_n;
        logic rd_n;
        logic wr_n;
        logic sample;
    } strobe_t;

    localparam pos_t    POS_START = '{st: state_t'(1), ph: phase_t'(1)};
    localparam req_t    REQ_NONE  = '{rd: 1'b0, wr: 1'b0, expd: 1'b0};
    localparam strobe_t STB_IDLE  = '{ale_n: 1'b1, prog_n: 1'b1, rd_n: 1'b1,
                                      wr_n: 1'b1, sample: 1'b0};

    function automatic pos_t pos_step(input pos_t p);
        pos_t n;
        n = p;
        if (p.ph == LAST_PH) begin
            n.ph = phase_t'(1);
            n.st = (p.st == LAST_ST) ? state_t'(1) : state_t'(p.st + 1'b1);
        end else begin
            n.ph = phase_t'(p.ph + 1'b1);
        end
        return n;
    endfunction

    function automatic logic is_capture(input pos_t p);
        return (p.st == CAP_ST) && (p.ph == LAST_PH);
    endfunction

    function automatic logic in_ale_window(input pos_t p);
        return ((p.st == ALE_ST) && (p.ph == LAST_PH)) ||
               ((p.st == state_t'(ALE_ST + 1'b1)) && (p.ph != LAST_PH));
    endfunction

    function automatic strobe_t shape(input pos_t p, input req_t r);
        strobe_t s;
        logic    xfr;
        xfr      = (p.st == XFR_ST);
        s.ale_n  = ~in_ale_window(p);
        s.rd_n   = ~(xfr & r.rd);
        s.wr_n   = ~(xfr & r.wr);
        s.prog_n = ~(xfr & r.expd & (p.ph == LAST_PH));
        s.sample = xfr & r.rd & (p.ph == LAST_PH);
        return s;
    endfunction

endpackage

// File: rtl/mcyc_seq.sv
module mcyc_seq
    import mcyc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    output pos_t pos_q,
    output pos_t pos_nxt
);

    always_comb begin
        pos_nxt = clk_en ? pos_step(pos_q) : pos_q;
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= POS_START;
        else     pos_q <= pos_nxt;
    end

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(pos_q));

    assert_cycle_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (clk_en && pos_q.st == LAST_ST && pos_q.ph == LAST_PH)
            |=> (pos_q.st == state_t'(1) && pos_q.ph == phase_t'(1)));

    assert_pos_range_R3: assert property (@(posedge clk) disable iff (rst)
        (pos_q.st >= state_t'(1)) && (pos_q.st <= LAST_ST) &&
        (pos_q.ph >= phase_t'(1)) && (pos_q.ph <= LAST_PH));

endmodule

// File: rtl/mcyc_req_latch.sv
module mcyc_req_latch
    import mcyc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    input  pos_t pos_q,
    input  logic req_rd,
    input  logic req_wr,
    input  logic req_exp,
    input  logic irq_pend,
    output req_t lat_q,
    output req_t lat_nxt
);

    logic irq_q;

    // interrupt sample runs on every crystal edge
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_pend;
    end

    always_comb begin
        lat_nxt = lat_q;
        if (clk_en && is_capture(pos_q)) begin
            lat_nxt.rd   = req_rd & ~irq_q;
            lat_nxt.wr   = req_wr;
            lat_nxt.expd = req_exp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= REQ_NONE;
        else     lat_q <= lat_nxt;
    end

    assert_irq_blocks_read_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_en && is_capture(pos_q) && irq_q) |=> !lat_q.rd);

    assert_write_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_en && is_capture(pos_q)) |=> (lat_q.wr == $past(req_wr)));

    assert_capture_only_R10: assert property (@(posedge clk) disable iff (rst)
        !(clk_en && is_capture(pos_q)) |=> $stable(lat_q));

endmodule

// File: rtl/mcyc_strobe.sv
module mcyc_strobe
    import mcyc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pos_t    pos_nxt,
    input  req_t    lat_nxt,
    output strobe_t stb_q
);

    // registered on the base clock from the position about to be entered
    always_ff @(posedge clk) begin
        if (rst) stb_q <= STB_IDLE;
        else     stb_q <= shape(pos_nxt, lat_nxt);
    end

endmodule

// File: rtl/mcyc_timing.sv
module mcyc_timing
    import mcyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_en,
    input  logic       req_rd,
    input  logic       req_wr,
    input  logic       req_exp,
    input  logic       irq_pend,
    output logic       ale_n,
    output logic       prog_n,
    output logic       rd_n,
    output logic       wr_n,
    output logic       bus_sample,
    output logic [2:0] mstate,
    output logic [1:0] xphase
);

    pos_t    pos_q;
    pos_t    pos_nxt;
    req_t    lat_q;
    req_t    lat_nxt;
    strobe_t stb_q;

    mcyc_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .clk_en  (clk_en),
        .pos_q   (pos_q),
        .pos_nxt (pos_nxt)
    );

    mcyc_req_latch u_lat (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .pos_q    (pos_q),
        .req_rd   (req_rd),
        .req_wr   (req_wr),
        .req_exp  (req_exp),
        .irq_pend (irq_pend),
        .lat_q    (lat_q),
        .lat_nxt  (lat_nxt)
    );

    mcyc_strobe u_stb (
        .clk     (clk),
        .rst     (rst),
        .pos_nxt (pos_nxt),
        .lat_nxt (lat_nxt),
        .stb_q   (stb_q)
    );

    assign ale_n      = stb_q.ale_n;
    assign prog_n     = stb_q.prog_n;
    assign rd_n       = stb_q.rd_n;
    assign wr_n       = stb_q.wr_n;
    assign bus_sample = stb_q.sample;
    assign mstate     = 3'(pos_q.st);
    assign xphase     = 2'(pos_q.ph);

    assert_ale_window_R4: assert property (@(posedge clk) disable iff (rst)
        !ale_n |-> ((mstate == 3'd4 && xphase == 2'd3) ||
                    (mstate == 3'd5 && xphase != 2'd3)));

    assert_read_in_state2_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (mstate == 3'd2));

    assert_write_in_state2_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (mstate == 3'd2));

    assert_prog_slot_R7: assert property (@(posedge clk) disable iff (rst)
        !prog_n |-> (mstate == 3'd2 && xphase == 2'd3));

    assert_sample_in_read_R8: assert property (@(posedge clk) disable iff (rst)
        bus_sample |-> (!rd_n && xphase == 2'd3));

endmodule

// File: tb/tb_mcyc_timing.sv
module tb_mcyc_timing;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_en = 1'b0;
    logic req_rd = 1'b0, req_wr = 1'b0, req_exp = 1'b0, irq_pend = 1'b0;
    logic ale_n, prog_n, rd_n, wr_n, bus_sample;
    logic [2:0] mstate;
    logic [1:0] xphase;

    always #2.5 clk = ~clk;

    mcyc_timing dut (
        .clk(clk), .rst(rst), .clk_en(clk_en),
        .req_rd(req_rd), .req_wr(req_wr), .req_exp(req_exp), .irq_pend(irq_pend),
        .ale_n(ale_n), .prog_n(prog_n), .rd_n(rd_n), .wr_n(wr_n),
        .bus_sample(bus_sample), .mstate(mstate), .xphase(xphase)
    );

    int n_chk = 0;
    int n_err = 0;

    // behavioural reference
    int m_st = 1, m_ph = 1;
    bit m_rd, m_wr, m_ex, m_irq;
    bit was_rst, was_en, started;
    bit done = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 1; m_ph = 1; m_rd = 0; m_wr = 0; m_ex = 0; m_irq = 0;
        end else begin
            if (clk_en && m_st == 1 && m_ph == 3) begin
                m_rd = req_rd && !m_irq;
                m_wr = req_wr;
                m_ex = req_exp;
            end
            m_irq = irq_pend;
            if (clk_en) begin
                if (m_ph == 3) begin
                    m_ph = 1;
                    m_st = (m_st == 5) ? 1 : m_st + 1;
                end else m_ph = m_ph + 1;
            end
        end
        was_rst = rst;
        was_en  = clk_en;
        started = 1;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    logic [12:0] prev_out;
    bit have_prev = 0;

    task automatic check_now();
        bit e_ale, e_rd, e_wr, e_prog, e_smp;
        logic [12:0] cur;
        if (!started) return;
        e_ale  = !((m_st == 4 && m_ph == 3) || (m_st == 5 && m_ph != 3));
        e_rd   = !(m_st == 2 && m_rd);
        e_wr   = !(m_st == 2 && m_wr);
        e_prog = !(m_st == 2 && m_ph == 3 && m_ex);
        e_smp  = (m_st == 2 && m_ph == 3 && m_rd);
        cur = {ale_n, prog_n, rd_n, wr_n, bus_sample, 3'(mstate), 2'(xphase), 3'b0};
        if (was_rst) begin
            chk("R1 reset position", {mstate, 3'(xphase)}, {3'd1, 3'd1});
            chk("R1 reset strobes", {3'b0, ale_n, prog_n, rd_n, wr_n, bus_sample},
                {3'b0, 5'b11110});
        end else begin
            chk("R3 state", 8'(mstate), 8'(m_st));
            chk("R3 phase", 8'(xphase), 8'(m_ph));
            chk("R4 ale_n", 8'(ale_n), 8'(e_ale));
            chk("R5 R9 R10 rd_n", 8'(rd_n), 8'(e_rd));
            chk("R6 wr_n", 8'(wr_n), 8'(e_wr));
            chk("R7 prog_n", 8'(prog_n), 8'(e_prog));
            chk("R8 bus_sample", 8'(bus_sample), 8'(e_smp));
            if (!was_en && have_prev)
                chk("R2 stall hold", 8'(cur[12:5]), 8'(prev_out[12:5]));
        end
        prev_out  = cur;
        have_prev = !was_rst;
    endtask

    task automatic step(input bit en, input bit rd, input bit wr, input bit ex, input bit irq);
        @(negedge clk);
        check_now();
        clk_en = en; req_rd = rd; req_wr = wr; req_exp = ex; irq_pend = irq;
    endtask

    initial begin
        repeat (3) step(0, 1, 1, 1, 1);
        rst = 1'b0;
        // free running, random requests
        for (int i = 0; i < 600; i++)
            step(1, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
        // random enable gaps
        for (int i = 0; i < 900; i++)
            step(($urandom % 3) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 3) == 0);
        // R9: interrupt and read collide, write still goes out
        for (int i = 0; i < 45; i++) step(1, 1, 1, 0, 1);
        for (int i = 0; i < 45; i++) step(1, 1, 0, 1, 0);
        // R10: requests high except at the capture edge
        for (int i = 0; i < 60; i++) begin
            bit cap;
            cap = (m_st == 1 && m_ph == 3);
            step(1, !cap, !cap, !cap, 0);
        end
        // mid-run reset
        @(negedge clk); rst = 1'b1;
        step(1, 1, 1, 1, 0);
        rst = 1'b0;
        for (int i = 0; i < 200; i++)
            step(($urandom % 4) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 5) == 0);
        @(negedge clk); check_now();
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule